// File: doc/BRIEF.md
# Debug Register Access Command Handler

This block runs the read and write commands that a debug host issues against a small bank of debug registers. The host moves 16-bit words over a simple word channel that stands in for the serial debug link. Every word the host sends produces one 17-bit response word one cycle later. The response carries whatever the engine had staged before that word arrived. Bit 16 of a response marks a status code, and a clear bit 16 marks a valid data halfword. Longword results go back as two halfwords, upper half first.

The bank holds one configuration/status register and a parameterised number of plain 32-bit registers. The configuration/status register keeps a breakpoint-level code and four sticky event flags, which breakpoint and event pulses from outside set. Reading it has side effects. The sticky flags clear once their values have been captured, and the level code clears only when a level-2 hit is recorded, or when a level-1 hit is recorded while level-2 breakpoints are disabled. Writes can be rejected by a bus-error input, and in that case nothing is committed.

Top module: `dbg_cmd_engine`

## Requirements
- R1: A command word carries its opcode in bits [15:12] and a register selector in bits [4:0]. Opcode 0x2 is a register read and opcode 0x3 is a register write. Any other opcode stages the ILLEGAL response (bit 16 = 1, data 0xFFFF).
- R2: Each word accepted while `in_valid` is high gives exactly one response, with `resp_valid` high on the following cycle. The response is the word staged before that transfer. After reset the staged word is the idle value 0x00000.
- R3: A read of selector 0x00 stages NOT READY (bit 16 = 1, data 0x0000) until it completes. The next word then returns bit 16 = 0 with status bits [31:16], and the word after that (already the next command) returns bits [15:0].
- R4: A read of any selector other than 0x00 stages ILLEGAL instead of data and starts no execution.
- R5: A word that arrives during execution (EXEC_LAT cycles after the last word of a command) returns NOT READY and is discarded.
- R6: A write command is followed by four operand words: selector upper, selector lower (bits [4:0] used), data upper, data lower. Selector 0 loads status bits [15:0]. Selector k in 1..NUM_WREG loads `wreg_q[k-1]`. Success stages 0x0FFFF, and any other selector stages ILLEGAL and commits nothing.
- R7: If `bus_err` is high in the completion cycle of a write, the response 0x10001 is staged and no register changes.
- R8: Status layout: [31:28] level code (0 none, 1 level-1 hit, 2 level-2 hit), [27] fault-on-fault, [26] trigger, [25] halt, [24] breakpoint, [23:16] zero, [15:0] control, where bit 0 enables level-2 breakpoints. The `ev_fault`, `ev_halt` and `ev_bkpt` pulses set their flags. The `bp1_hit` and `bp2_hit` pulses set the trigger flag and the level code.
- R9: A status read returns the flags as they were before the read, then clears all four flags.
- R10: A status read clears the level code when it is 2, or when it is 1 and control bit 0 is clear. Otherwise the level code is kept.
- R11: An event pulse in the same cycle as a read-clear wins, and the flag reads as set afterwards.
- R12: A level-1 hit never lowers a recorded level-2 code.
- R13: Reset clears all registers, the flags, the level code and `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host word present this cycle |
| in_word | input | 16 | Host command or operand word |
| bus_err | input | 1 | Write bus error, sampled at write completion |
| bp1_hit | input | 1 | Level-1 breakpoint hit pulse |
| bp2_hit | input | 1 | Level-2 breakpoint hit pulse |
| ev_fault | input | 1 | Fault-on-fault event pulse |
| ev_halt | input | 1 | Halt event pulse |
| ev_bkpt | input | 1 | Breakpoint-request event pulse |
| resp_valid | output | 1 | Response word present |
| resp_word | output | 17 | Response: bit 16 status flag, bits [15:0] data |
| wreg_q | output | NUM_WREG x 32 | Contents of the plain writable registers |

## Verification
A table of back-to-back command streams runs valid reads, reads of bad selectors, unknown opcodes, writes to every kind of selector, and words sent while a command is busy. This shows the staged-response pipeline apart from the decoding. Directed sequences then raise every combination of flags and level codes that the clear rule distinguishes: level-1 with level-2 enabled and disabled, level-2, and level-1 after level-2. They also place an event exactly on the read-completion edge, which separates set-wins from clear-wins. Bus-error writes are paired with clean writes to the same register, so that a missed commit and a wrong commit show up differently.

// File: rtl/dbg_pkg.sv
// Package: shared encodings for the debug command engine.
// Assumes 16-bit link words and 17-bit responses (bit 16 = status flag).
package dbg_pkg;
    localparam int WORD_W = 16;
    localparam int RESP_W = 17;
    localparam int LONG_W = 32;
    localparam int SEL_W  = 5;

    localparam logic [3:0] OP_READ  = 4'h2;
    localparam logic [3:0] OP_WRITE = 4'h3;

    localparam logic [RESP_W-1:0] RSP_IDLE      = 17'h00000;
    localparam logic [RESP_W-1:0] RSP_NOT_READY = 17'h10000;
    localparam logic [RESP_W-1:0] RSP_ILLEGAL   = 17'h1FFFF;
    localparam logic [RESP_W-1:0] RSP_WR_DONE   = 17'h0FFFF;
    localparam logic [RESP_W-1:0] RSP_BUS_ERR   = 17'h10001;

    localparam logic [3:0] LVL_NONE = 4'h0;
    localparam logic [3:0] LVL_ONE  = 4'h1;
    localparam logic [3:0] LVL_TWO  = 4'h2;

    typedef enum logic [1:0] {ST_CMD, ST_OPER, ST_EXEC, ST_MS} seq_state_t;
    typedef enum logic [1:0] {JOB_NONE, JOB_READ, JOB_WRITE} job_t;

    typedef struct packed {
        logic [3:0] lvl;
        logic       fof;
        logic       trg;
        logic       halt;
        logic       bkpt;
    } evt_t;
endpackage

// File: rtl/dbg_csr.sv
// Module: configuration/status register with sticky event bits.
// Holds the level code, four sticky flags and a writable control half.
// Assumes rd_clr is a one-cycle pulse at read completion, after the caller
// has sampled csr_value; event pulses take priority over that clear.
module dbg_csr
    import dbg_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bp1_hit,
    input  logic              bp2_hit,
    input  logic              ev_fault,
    input  logic              ev_halt,
    input  logic              ev_bkpt,
    input  logic              rd_clr,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [LONG_W-1:0] csr_value
);
    localparam int GAP_W = LONG_W - 8 - CTRL_W;

    evt_t              evt_q, evt_n;
    logic [CTRL_W-1:0] ctrl_q;
    logic              l2_en;

    assign l2_en = ctrl_q[0];

    // Next event state: conditional clear first, then pulses override.
    always_comb begin
        evt_n = evt_q;
        if (rd_clr) begin
            evt_n.fof  = 1'b0;
            evt_n.trg  = 1'b0;
            evt_n.halt = 1'b0;
            evt_n.bkpt = 1'b0;
            if (evt_q.lvl == LVL_TWO || (evt_q.lvl == LVL_ONE && !l2_en))
                evt_n.lvl = LVL_NONE;
        end
        if (ev_fault)            evt_n.fof  = 1'b1;
        if (ev_halt)             evt_n.halt = 1'b1;
        if (ev_bkpt)             evt_n.bkpt = 1'b1;
        if (bp1_hit || bp2_hit)  evt_n.trg  = 1'b1;
        if (bp2_hit)
            evt_n.lvl = LVL_TWO;
        else if (bp1_hit && evt_n.lvl != LVL_TWO)
            evt_n.lvl = LVL_ONE;
    end

    // Event state register.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_n;
    end

    // Control half register, loaded by debug writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    assign csr_value = {evt_q, {GAP_W{1'b0}}, ctrl_q};

    // R11: a halt pulse always leaves the flag set, even during a read-clear.
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt |=> csr_value[25]);

    // R9: a read-clear without a new fault pulse leaves fault-on-fault clear.
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev_fault) |=> !csr_value[27]);

    // R12: level-2 code survives anything but a read-clear.
    p_level_two_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_value[31:28] == LVL_TWO && !rd_clr) |=> (csr_value[31:28] == LVL_TWO));
endmodule

// File: rtl/dbg_wregs.sv
// Module: bank of plain writable debug registers.
// Register i answers to selector i+1; selector 0 belongs to the status register.
// Assumes we is already qualified by bus-error and selector range checks.
module dbg_wregs
    import dbg_pkg::*;
#(
    parameter int NUM_REG = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [SEL_W-1:0]               sel,
    input  logic [LONG_W-1:0]              wdata,
    output logic [NUM_REG-1:0][LONG_W-1:0] regs
);
    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        // One register, loaded when its selector is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && sel == SEL_W'(i + 1))
                regs[i] <= wdata;
        end
    end

    // R6: no register moves without a qualified write strobe.
    p_hold_without_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs));
endmodule

// File: rtl/dbg_cmd_seq.sv
// Module: command sequencer for the debug word link.
// Decodes command words, gathers write operands, times execution and stages
// the response word returned on the next transfer.
// Assumes EXEC_LAT >= 2 so the word right after a command sees NOT READY.
module dbg_cmd_seq
    import dbg_pkg::*;
#(
    parameter int EXEC_LAT = 4,
    parameter int NUM_WREG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              bus_err,
    input  logic [LONG_W-1:0] csr_value,
    output logic              resp_valid,
    output logic [RESP_W-1:0] resp_word,
    output logic              csr_rd_clr,
    output logic              csr_we,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [LONG_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(EXEC_LAT + 1);

    seq_state_t         state;
    job_t               job;
    logic [CNT_W-1:0]   cnt;
    logic [1:0]         oper_cnt;
    logic [SEL_W-1:0]   sel_q;
    logic [LONG_W-1:0]  data_q;
    logic [WORD_W-1:0]  ls_hold;
    logic [RESP_W-1:0]  slot;

    logic [3:0]         opcode;
    logic [SEL_W-1:0]   cmd_sel;
    logic               exec_done;
    logic               sel_ok;
    logic               write_go;

    assign opcode    = in_word[15:12];
    assign cmd_sel   = in_word[SEL_W-1:0];
    assign exec_done = (state == ST_EXEC) && (cnt == CNT_W'(1));
    assign sel_ok    = (sel_q == '0) || (int'(sel_q) <= NUM_WREG);
    assign write_go  = exec_done && (job == JOB_WRITE) && sel_ok && !bus_err;

    assign csr_we     = write_go && (sel_q == '0);
    assign wr_en      = write_go && (sel_q != '0);
    assign wr_sel     = sel_q;
    assign wr_data    = data_q;
    assign csr_rd_clr = exec_done && (job == JOB_READ);

    // Response register: every transfer returns the previously staged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_word  <= RSP_IDLE;
        end else begin
            resp_valid <= in_valid;
            if (in_valid) resp_word <= slot;
        end
    end

    // Sequencer: decode, operand gathering, execution timing, result staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            job      <= JOB_NONE;
            cnt      <= '0;
            oper_cnt <= '0;
            sel_q    <= '0;
            data_q   <= '0;
            ls_hold  <= '0;
            slot     <= RSP_IDLE;
        end else begin
            unique case (state)
                ST_CMD: begin
                    if (in_valid) begin
                        if (opcode == OP_READ) begin
                            if (cmd_sel == '0) begin
                                state <= ST_EXEC;
                                job   <= JOB_READ;
                                cnt   <= CNT_W'(EXEC_LAT);
                                slot  <= RSP_NOT_READY;
                            end else begin
                                slot  <= RSP_ILLEGAL;
                            end
                        end else if (opcode == OP_WRITE) begin
                            state    <= ST_OPER;
                            oper_cnt <= '0;
                            slot     <= RSP_NOT_READY;
                        end else begin
                            slot <= RSP_ILLEGAL;
                        end
                    end
                end
                ST_OPER: begin
                    if (in_valid) begin
                        if (oper_cnt == 2'd1)
                            sel_q <= in_word[SEL_W-1:0];
                        if (oper_cnt >= 2'd2)
                            data_q <= {data_q[WORD_W-1:0], in_word};
                        oper_cnt <= oper_cnt + 2'd1;
                        if (oper_cnt == 2'd3) begin
                            state <= ST_EXEC;
                            job   <= JOB_WRITE;
                            cnt   <= CNT_W'(EXEC_LAT);
                        end
                    end
                end
                ST_EXEC: begin
                    cnt <= cnt - CNT_W'(1);
                    if (exec_done) begin
                        job <= JOB_NONE;
                        if (job == JOB_READ) begin
                            slot    <= {1'b0, csr_value[LONG_W-1:WORD_W]};
                            ls_hold <= csr_value[WORD_W-1:0];
                            state   <= ST_MS;
                        end else begin
                            if (!sel_ok)      slot <= RSP_ILLEGAL;
                            else if (bus_err) slot <= RSP_BUS_ERR;
                            else              slot <= RSP_WR_DONE;
                            state <= ST_CMD;
                        end
                    end
                end
                ST_MS: begin
                    if (in_valid) begin
                        slot  <= {1'b0, ls_hold};
                        state <= ST_CMD;
                    end
                end
                default: state <= ST_CMD;
            endcase
        end
    end

    // R2: one response follows each accepted word, and none otherwise.
    p_resp_per_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> resp_valid);
    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !resp_valid);

    // R5: words arriving during execution are answered NOT READY.
    p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && in_valid) |=> (resp_word == RSP_NOT_READY));

    // R4: a read of a non-status selector stages ILLEGAL and starts nothing.
    p_bad_read_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && in_valid && opcode == OP_READ && cmd_sel != '0)
        |=> (slot == RSP_ILLEGAL && state == ST_CMD));

    // R7: a bus error at completion blocks every register write.
    p_buserr_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && bus_err) |-> !(wr_en || csr_we));

    // R6: at most one of read-clear, status write and bank write per cycle.
    p_single_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, csr_we, csr_rd_clr}));
endmodule

// File: rtl/dbg_cmd_engine.sv
// Module: top of the debug register access command handler.
// Joins the sequencer, the status register and the plain register bank.
// Assumes the host paces words itself; words sent while busy are dropped.
module dbg_cmd_engine
    import dbg_pkg::*;
#(
    parameter int EXEC_LAT = 4,
    parameter int NUM_WREG = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [15:0]                     in_word,
    input  logic                            bus_err,
    input  logic                            bp1_hit,
    input  logic                            bp2_hit,
    input  logic                            ev_fault,
    input  logic                            ev_halt,
    input  logic                            ev_bkpt,
    output logic                            resp_valid,
    output logic [16:0]                     resp_word,
    output logic [NUM_WREG-1:0][31:0]       wreg_q
);
    localparam int CTRL_W = 16;

    logic [LONG_W-1:0] csr_value;
    logic              csr_rd_clr;
    logic              csr_we;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_sel;
    logic [LONG_W-1:0] wr_data;

    dbg_cmd_seq #(
        .EXEC_LAT (EXEC_LAT),
        .NUM_WREG (NUM_WREG)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .bus_err    (bus_err),
        .csr_value  (csr_value),
        .resp_valid (resp_valid),
        .resp_word  (resp_word),
        .csr_rd_clr (csr_rd_clr),
        .csr_we     (csr_we),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data)
    );

    dbg_csr #(
        .CTRL_W (CTRL_W)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bp1_hit    (bp1_hit),
        .bp2_hit    (bp2_hit),
        .ev_fault   (ev_fault),
        .ev_halt    (ev_halt),
        .ev_bkpt    (ev_bkpt),
        .rd_clr     (csr_rd_clr),
        .ctrl_we    (csr_we),
        .ctrl_wdata (wr_data[CTRL_W-1:0]),
        .csr_value  (csr_value)
    );

    dbg_wregs #(
        .NUM_REG (NUM_WREG)
    ) u_wregs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .sel   (wr_sel),
        .wdata (wr_data),
        .regs  (wreg_q)
    );
endmodule

// File: tb/sim_dbg_cmd_engine.sv
`timescale 1ns/1ps
module sim_dbg_cmd_engine;
    localparam int LAT  = 4;
    localparam int NREG = 3;
    localparam int GAP  = LAT + 2;
    localparam int NVEC = 28;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [15:0]      in_word = '0;
    logic             bus_err = 1'b0;
    logic             bp1_hit = 1'b0, bp2_hit = 1'b0;
    logic             ev_fault = 1'b0, ev_halt = 1'b0, ev_bkpt = 1'b0;
    logic             resp_valid;
    logic [16:0]      resp_word;
    logic [NREG-1:0][31:0] wreg_q;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dbg_cmd_engine #(.EXEC_LAT(LAT), .NUM_WREG(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .bus_err(bus_err), .bp1_hit(bp1_hit), .bp2_hit(bp2_hit),
        .ev_fault(ev_fault), .ev_halt(ev_halt), .ev_bkpt(ev_bkpt),
        .resp_valid(resp_valid), .resp_word(resp_word), .wreg_q(wreg_q)
    );

    // Vector: {req[3:0], idle cycles after[7:0], expected response[16:0], word[15:0]}
    localparam logic [44:0] VEC [0:NVEC-1] = '{
        {4'd2,  8'd0, 17'h00000, 16'h2000}, // R2 idle slot; read status
        {4'd5,  8'd6, 17'h10000, 16'h0000}, // R5 busy word -> NOT READY
        {4'd3,  8'd0, 17'h00000, 16'h0000}, // R3 upper half
        {4'd3,  8'd0, 17'h00000, 16'h2001}, // R3 lower half; bad read
        {4'd4,  8'd0, 17'h1FFFF, 16'h0000}, // R4 ILLEGAL; opcode 0
        {4'd1,  8'd0, 17'h1FFFF, 16'h3000}, // R1 unknown opcode; write
        {4'd6,  8'd0, 17'h10000, 16'h0000},
        {4'd6,  8'd0, 17'h10000, 16'h0002},
        {4'd6,  8'd0, 17'h10000, 16'hA5A5},
        {4'd6,  8'd6, 17'h10000, 16'h1234},
        {4'd6,  8'd0, 17'h0FFFF, 16'h3000}, // R6 done; write status
        {4'd6,  8'd0, 17'h10000, 16'h0000},
        {4'd6,  8'd0, 17'h10000, 16'h0000},
        {4'd6,  8'd0, 17'h10000, 16'hFFFF},
        {4'd6,  8'd6, 17'h10000, 16'h0001},
        {4'd6,  8'd6, 17'h0FFFF, 16'h2000}, // R6 done; read status
        {4'd8,  8'd0, 17'h00000, 16'h0000}, // R8 upper half not writable
        {4'd8,  8'd0, 17'h00001, 16'h3000}, // R8 control bit 0 set
        {4'd6,  8'd0, 17'h10000, 16'h0000},
        {4'd6,  8'd0, 17'h10000, 16'h0007},
        {4'd6,  8'd0, 17'h10000, 16'h1111},
        {4'd6,  8'd6, 17'h10000, 16'h2222},
        {4'd6,  8'd0, 17'h1FFFF, 16'h3000}, // R6 bad selector -> ILLEGAL
        {4'd6,  8'd0, 17'h10000, 16'h0000},
        {4'd6,  8'd0, 17'h10000, 16'h0001},
        {4'd6,  8'd0, 17'h10000, 16'hDEAD},
        {4'd6,  8'd6, 17'h10000, 16'hBEEF},
        {4'd6,  8'd0, 17'h0FFFF, 16'h0000}  // R6 done
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [15:0] w, output logic [16:0] r);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        r = resp_word;
        chk("R2 resp_valid", 32'(resp_valid), 32'd1);
    endtask

    task automatic do_read(output logic [16:0] ms, output logic [16:0] ls);
        logic [16:0] r;
        xfer(16'h2000, r);
        idle(GAP);
        xfer(16'h0000, ms);
        xfer(16'hF000, ls);
    endtask

    task automatic do_write(input logic [4:0] sel, input logic [31:0] d, output logic [16:0] st);
        logic [16:0] r;
        xfer(16'h3000, r);
        xfer(16'h0000, r);
        xfer({11'h0, sel}, r);
        xfer(d[31:16], r);
        xfer(d[15:0], r);
        idle(GAP);
        xfer(16'hF000, st);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [16:0] r, ms, ls;
        @(negedge clk);
        idle(2);
        // R13 reset state
        chk("R13 resp_valid", 32'(resp_valid), 32'd0);
        for (int i = 0; i < NREG; i++) chk("R13 wreg", wreg_q[i], 32'h0);
        rst_n = 1'b1;
        idle(1);

        // Table walk: R1 R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][15:0], r);
            chk($sformatf("R%0d vector %0d", VEC[v][44:41], v), 32'(r), 32'(VEC[v][32:16]));
            idle(int'(VEC[v][40:33]));
        end
        chk("R6 wreg sel2", wreg_q[1], 32'hA5A51234);
        chk("R6 wreg sel1", wreg_q[0], 32'hDEADBEEF);
        chk("R6 wreg sel3 untouched", wreg_q[2], 32'h0);

        // R8 R9 R10: all flags plus level-1 with level-2 enabled
        ev_fault = 1; ev_halt = 1; ev_bkpt = 1; bp1_hit = 1;
        idle(1);
        ev_fault = 0; ev_halt = 0; ev_bkpt = 0; bp1_hit = 0;
        do_read(ms, ls);
        chk("R8 status upper", 32'(ms), 32'h01F00);
        chk("R8 status lower", 32'(ls), 32'h00001);
        do_read(ms, ls);
        chk("R10 level-1 kept with level-2 enabled", 32'(ms), 32'h01000);

        // R10: disable level-2, level-1 code now clears
        do_write(5'd0, 32'h0, r);
        chk("R6 status write", 32'(r), 32'h0FFFF);
        do_read(ms, ls);
        chk("R10 level-1 before clear", 32'(ms), 32'h01000);
        do_read(ms, ls);
        chk("R10 level-1 cleared", 32'(ms), 32'h00000);

        // R10: level-2 code clears on read
        bp2_hit = 1; idle(1); bp2_hit = 0;
        do_read(ms, ls);
        chk("R10 level-2 seen", 32'(ms), 32'h02400);
        do_read(ms, ls);
        chk("R10 level-2 cleared", 32'(ms), 32'h00000);

        // R12: level-1 after level-2 keeps code 2
        bp2_hit = 1; idle(1); bp2_hit = 0;
        bp1_hit = 1; idle(1); bp1_hit = 0;
        do_read(ms, ls);
        chk("R12 level-2 not lowered", 32'(ms), 32'h02400);
        do_read(ms, ls);
        chk("R12 cleared after read", 32'(ms), 32'h00000);

        // R11: halt pulse on the read completion edge
        xfer(16'h2000, r);
        idle(LAT - 1);
        ev_halt = 1; idle(1); ev_halt = 0;
        idle(2);
        xfer(16'h0000, ms);
        xfer(16'hF000, ls);
        chk("R11 captured before set", 32'(ms), 32'h00000);
        do_read(ms, ls);
        chk("R11 set wins over clear", 32'(ms), 32'h00200);

        // R7: bus error blocks the commit, clean write then lands
        bus_err = 1'b1;
        do_write(5'd3, 32'h55AA55AA, r);
        bus_err = 1'b0;
        chk("R7 bus error response", 32'(r), 32'h10001);
        chk("R7 no commit", wreg_q[2], 32'h0);
        do_write(5'd3, 32'h55AA55AA, r);
        chk("R6 clean write response", 32'(r), 32'h0FFFF);
        chk("R6 clean write commit", wreg_q[2], 32'h55AA55AA);

        // R13: mid-run reset clears registers and flags
        ev_fault = 1; idle(1); ev_fault = 0;
        rst_n = 1'b0;
        idle(2);
        chk("R13 reset wreg", wreg_q[2], 32'h0);
        chk("R13 reset resp_valid", 32'(resp_valid), 32'd0);
        rst_n = 1'b1;
        idle(1);
        do_read(ms, ls);
        chk("R13 flags cleared", 32'(ms), 32'h00000);

        finish_run();
    end
endmodule